// File: doc/BRIEF.md
# USB Endpoint FIFO Flush Controller

This block is a byte-wide, write-only command register. A CPU writes it to empty the FIFOs of a USB function's endpoints. Four bits of the written byte each request one flush. Two bits cover the control endpoint: one for the FIFO the host writes into, and one for the FIFO the host reads from. The other two bits cover the two halves of the bulk-IN FIFO: the half the CPU fills and the half the serial engine drains. An accepted request becomes a one-cycle pulse on that FIFO's clear output. The pulse resets the FIFO's read pointer, write pointer and byte count together.

The block also holds the three NAK flags that a flush touches. Each flag is a three-state machine: NAK_OFF (flag low), NAK_BY_FW (set by firmware) and NAK_BY_HW (set by the serial engine). There are four transitions:

- fw_set moves a flag from any state to NAK_BY_FW.
- hw_set moves a flag from NAK_OFF to NAK_BY_HW.
- An accepted flush moves the flag it affects to NAK_OFF.
- The one exception is the control-read flag: a flush leaves it in NAK_BY_FW.

Two flushes are blocked while the engine is serving an IN token and the related NAK flag is high. Flushes for endpoints that the present configuration does not support are dropped.

Top module: `fifo_clr_ctrl`

## Requirements
- R1: A read of the register address returns 0x00 on `bus_rdata_o`, including directly after a write of 1s.
- R2: A write hitting `CLR_ADDR` with bit 0, 1, 4 or 5 set raises `clr_ep0_rd_o`, `clr_ep0_wr_o`, `clr_ep1_cpu_o` or `clr_ep1_sie_o` for exactly the one cycle after the write edge. The pulse does not repeat unless the bit is written again.
- R3: Nothing pulses in these cases: a 0 is written to a clear bit, a bit among 7, 6, 3 and 2 is written, a write goes to another address, or only a read strobe is given.
- R4: A bit 5 write is ignored while `ep1_in_busy_i` is 1 and the endpoint-1 IN NAK flag is 1.
- R5: A bit 1 write is ignored while `ep0_in_busy_i` is 1 and the endpoint-0 write-side NAK flag is 1.
- R6: An accepted bit 5 flush drives the endpoint-1 IN NAK flag to 0 at the write edge. An accepted bit 1 flush does the same for the endpoint-0 write-side NAK flag, whoever set it.
- R7: An accepted bit 0 flush drives the endpoint-0 read-side NAK flag to 0 only when the engine set it. A flag set by firmware stays 1.
- R8: With `ep_support_i[0]`=0, bits 0 and 1 have no effect. With `ep_support_i[1]`=0, bits 4 and 5 have no effect.
- R9: The NAK strobe vectors index the flags as [0] endpoint-0 read side, [1] endpoint-0 write side and [2] endpoint-1 IN. A `fw_set_nak_i` bit raises its flag one edge later as firmware-set, even in the same cycle as a flush or an engine set. A `hw_set_nak_i` bit raises a low flag as engine-set. An engine set on a firmware-set flag leaves it firmware-set.
- R10: Several valid bits written in one cycle all pulse in the same cycle.
- R11: After reset all clear pulses and all NAK flags are 0.
- R12: An accepted flush wins over an engine set of the same flag in the same cycle, so the flag ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | CPU write strobe |
| bus_rd_i | input | 1 | CPU read strobe |
| bus_addr_i | input | ADDR_W | CPU address |
| bus_wdata_i | input | 8 | CPU write data |
| bus_rdata_o | output | 8 | CPU read data, always 0x00 |
| ep_support_i | input | 2 | [0] control endpoint usable, [1] bulk-IN endpoint usable |
| ep0_in_busy_i | input | 1 | Engine is serving an IN token on endpoint 0 |
| ep1_in_busy_i | input | 1 | Engine is serving an IN token on endpoint 1 |
| fw_set_nak_i | input | 3 | Firmware set strobes for the NAK flags |
| hw_set_nak_i | input | 3 | Engine set strobes for the NAK flags |
| nak_ep0_rd_o | output | 1 | Endpoint-0 read-side NAK flag |
| nak_ep0_wr_o | output | 1 | Endpoint-0 write-side NAK flag |
| nak_ep1_in_o | output | 1 | Endpoint-1 IN NAK flag |
| clr_ep0_rd_o | output | 1 | Control read FIFO clear pulse |
| clr_ep0_wr_o | output | 1 | Control write FIFO clear pulse |
| clr_ep1_cpu_o | output | 1 | Bulk-IN CPU-side clear pulse |
| clr_ep1_sie_o | output | 1 | Bulk-IN engine-side clear pulse |

## Verification
Each NAK flag's source state cannot be seen directly, so a wrong source state shows up later as a wrong reaction. A firmware-set read flag that was recorded as engine-set drops on the next bit 0 flush. A wrong flag value changes whether bit 1 or bit 5 is blocked, and that shows as a missing or extra pulse in the cycle after the write. Each cycle's expected pulses and flag levels are therefore compared one edge after that cycle's stimulus. Divergences then surface within a single cycle of the write that exposes them.

// File: rtl/fifo_clr_pkg.sv
package fifo_clr_pkg;

    localparam int REG_W   = 8;
    localparam int NUM_CLR = 4;
    localparam int NUM_NAK = 3;
    localparam int NUM_EP  = 2;

    // clear channel indices
    localparam int CH_EP0_RD  = 0;
    localparam int CH_EP0_WR  = 1;
    localparam int CH_EP1_CPU = 2;
    localparam int CH_EP1_SIE = 3;

    // NAK flag indices
    localparam int NAK_EP0_RD = 0;
    localparam int NAK_EP0_WR = 1;
    localparam int NAK_EP1_IN = 2;

    localparam logic [REG_W-1:0] READ_VALUE = '0;

    typedef enum logic [1:0] {
        NAK_OFF   = 2'd0,
        NAK_BY_FW = 2'd1,
        NAK_BY_HW = 2'd2
    } nak_state_e;

    // bit position in the written byte that requests a channel
    function automatic int clr_bit(input int ch);
        case (ch)
            CH_EP0_RD:  return 0;
            CH_EP0_WR:  return 1;
            CH_EP1_CPU: return 4;
            default:    return 5;
        endcase
    endfunction

    // endpoint whose support enables a channel
    function automatic int clr_ep(input int ch);
        return (ch >= CH_EP1_CPU) ? 1 : 0;
    endfunction

    // channel that flushes the FIFO tied to a NAK flag
    function automatic int nak_ch(input int n);
        case (n)
            NAK_EP0_RD: return CH_EP0_RD;
            NAK_EP0_WR: return CH_EP0_WR;
            default:    return CH_EP1_SIE;
        endcase
    endfunction

endpackage

// File: rtl/fifo_clr_decode.sv
module fifo_clr_decode
    import fifo_clr_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h79
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bus_wr_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [REG_W-1:0]    bus_wdata_i,
    input  logic [NUM_EP-1:0]   ep_support_i,
    input  logic                ep0_in_busy_i,
    input  logic                ep1_in_busy_i,
    input  logic                nak_ep0_wr_i,
    input  logic                nak_ep1_in_i,
    output logic [NUM_CLR-1:0]  clr_req_o,
    output logic [NUM_CLR-1:0]  clr_pulse_o
);

    logic wr_hit;
    logic [NUM_CLR-1:0] clr_q;

    assign wr_hit = bus_wr_i && (bus_addr_i == CLR_ADDR);

    for (genvar ch = 0; ch < NUM_CLR; ch++) begin : g_ch
        localparam int BITP = clr_bit(ch);
        localparam int EPN  = clr_ep(ch);
        logic blocked;

        if (ch == CH_EP0_WR) begin : g_lock0
            assign blocked = ep0_in_busy_i && nak_ep0_wr_i;
        end else if (ch == CH_EP1_SIE) begin : g_lock1
            assign blocked = ep1_in_busy_i && nak_ep1_in_i;
        end else begin : g_free
            assign blocked = 1'b0;
        end

        assign clr_req_o[ch] = wr_hit && bus_wdata_i[BITP]
                               && ep_support_i[EPN] && !blocked;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) clr_q[ch] <= 1'b0;
            else         clr_q[ch] <= clr_req_o[ch];
        end

        // a pulse always traces back to a register write of its bit
        p_pulse_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            clr_q[ch] |-> $past(bus_wr_i && bus_wdata_i[BITP]));

        // unsupported endpoints never flush
        p_unsupported_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!ep_support_i[EPN]) |=> !clr_q[ch]);
    end

    assign clr_pulse_o = clr_q;

    p_lock_sie_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ep1_in_busy_i && nak_ep1_in_i) |=> !clr_q[CH_EP1_SIE]);

    p_lock_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ep0_in_busy_i && nak_ep0_wr_i) |=> !clr_q[CH_EP0_WR]);

endmodule

// File: rtl/nak_flag_fsm.sv
module nak_flag_fsm
    import fifo_clr_pkg::*;
#(
    parameter bit KEEP_FW = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fw_set_i,
    input  logic hw_set_i,
    input  logic flush_i,
    output logic nak_o
);

    nak_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= NAK_OFF;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NAK_OFF: begin
                if (fw_set_i)      state_d = NAK_BY_FW;
                else if (flush_i)  state_d = NAK_OFF;
                else if (hw_set_i) state_d = NAK_BY_HW;
            end
            NAK_BY_FW: begin
                if (fw_set_i)                 state_d = NAK_BY_FW;
                else if (flush_i && !KEEP_FW) state_d = NAK_OFF;
            end
            NAK_BY_HW: begin
                if (fw_set_i)     state_d = NAK_BY_FW;
                else if (flush_i) state_d = NAK_OFF;
            end
            default: state_d = NAK_OFF;
        endcase
    end

    always_comb begin
        nak_o = (state_q != NAK_OFF);
    end

    p_fw_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fw_set_i |=> (state_q == NAK_BY_FW));

    p_flush_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flush_i && hw_set_i && !fw_set_i && (state_q != NAK_BY_FW)) |=> !nak_o);

    if (KEEP_FW) begin : g_keep
        p_fw_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (state_q == NAK_BY_FW) |=> nak_o);
    end else begin : g_drop
        p_flush_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flush_i && !fw_set_i) |=> !nak_o);
    end

endmodule

// File: rtl/fifo_clr_ctrl.sv
module fifo_clr_ctrl
    import fifo_clr_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h79
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bus_wr_i,
    input  logic                bus_rd_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [7:0]          bus_wdata_i,
    output logic [7:0]          bus_rdata_o,
    input  logic [1:0]          ep_support_i,
    input  logic                ep0_in_busy_i,
    input  logic                ep1_in_busy_i,
    input  logic [2:0]          fw_set_nak_i,
    input  logic [2:0]          hw_set_nak_i,
    output logic                nak_ep0_rd_o,
    output logic                nak_ep0_wr_o,
    output logic                nak_ep1_in_o,
    output logic                clr_ep0_rd_o,
    output logic                clr_ep0_wr_o,
    output logic                clr_ep1_cpu_o,
    output logic                clr_ep1_sie_o
);

    logic [NUM_CLR-1:0] clr_req;
    logic [NUM_CLR-1:0] clr_pulse;
    logic [NUM_NAK-1:0] nak;
    logic               rd_hit;

    assign rd_hit      = bus_rd_i && (bus_addr_i == CLR_ADDR);
    assign bus_rdata_o = rd_hit ? READ_VALUE : '0;

    fifo_clr_decode #(
        .ADDR_W   (ADDR_W),
        .CLR_ADDR (CLR_ADDR)
    ) u_decode (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .bus_wr_i      (bus_wr_i),
        .bus_addr_i    (bus_addr_i),
        .bus_wdata_i   (bus_wdata_i),
        .ep_support_i  (ep_support_i),
        .ep0_in_busy_i (ep0_in_busy_i),
        .ep1_in_busy_i (ep1_in_busy_i),
        .nak_ep0_wr_i  (nak[NAK_EP0_WR]),
        .nak_ep1_in_i  (nak[NAK_EP1_IN]),
        .clr_req_o     (clr_req),
        .clr_pulse_o   (clr_pulse)
    );

    for (genvar n = 0; n < NUM_NAK; n++) begin : g_nak
        nak_flag_fsm #(
            .KEEP_FW (n == NAK_EP0_RD)
        ) u_flag (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .fw_set_i (fw_set_nak_i[n]),
            .hw_set_i (hw_set_nak_i[n]),
            .flush_i  (clr_req[nak_ch(n)]),
            .nak_o    (nak[n])
        );
    end

    assign nak_ep0_rd_o  = nak[NAK_EP0_RD];
    assign nak_ep0_wr_o  = nak[NAK_EP0_WR];
    assign nak_ep1_in_o  = nak[NAK_EP1_IN];
    assign clr_ep0_rd_o  = clr_pulse[CH_EP0_RD];
    assign clr_ep0_wr_o  = clr_pulse[CH_EP0_WR];
    assign clr_ep1_cpu_o = clr_pulse[CH_EP1_CPU];
    assign clr_ep1_sie_o = clr_pulse[CH_EP1_SIE];

    // a read never returns anything but zero
    p_read_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rd_i |-> (bus_rdata_o == 8'h00));

    // a sie-side flush drops the endpoint-1 IN NAK unless firmware re-sets it
    p_sie_flush_nak_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_req[CH_EP1_SIE] && !fw_set_nak_i[NAK_EP1_IN]) |=> (!nak_ep1_in_o && clr_ep1_sie_o));

endmodule

// File: tb/fifo_clr_ctrl_test.sv
module fifo_clr_ctrl_test;

    localparam logic [7:0] ADDR = 8'h79;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] addr = '0, wdata = '0, rdata;
    logic [1:0] sup = 2'b11;
    logic       busy0 = 1'b0, busy1 = 1'b0;
    logic [2:0] fws = '0, hws = '0;
    logic       n_rd, n_wr, n_in;
    logic       c_rd, c_wr, c_cpu, c_sie;

    int cycle = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench-side flag model: 0 off, 1 firmware-set, 2 engine-set
    int m_nak [3] = '{0, 0, 0};

    typedef struct {
        logic [3:0] clr;
        logic [2:0] nak;
        int         due;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    fifo_clr_ctrl #(.ADDR_W(8), .CLR_ADDR(ADDR)) uut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .bus_wr_i      (wr),
        .bus_rd_i      (rd),
        .bus_addr_i    (addr),
        .bus_wdata_i   (wdata),
        .bus_rdata_o   (rdata),
        .ep_support_i  (sup),
        .ep0_in_busy_i (busy0),
        .ep1_in_busy_i (busy1),
        .fw_set_nak_i  (fws),
        .hw_set_nak_i  (hws),
        .nak_ep0_rd_o  (n_rd),
        .nak_ep0_wr_o  (n_wr),
        .nak_ep1_in_o  (n_in),
        .clr_ep0_rd_o  (c_rd),
        .clr_ep0_wr_o  (c_wr),
        .clr_ep1_cpu_o (c_cpu),
        .clr_ep1_sie_o (c_sie)
    );

    function automatic logic [2:0] nak_bits();
        return {m_nak[2] != 0, m_nak[1] != 0, m_nak[0] != 0};
    endfunction

    // driver: applies one cycle of stimulus at a falling edge and queues expectations
    task automatic drive(input logic w, input logic r, input logic [7:0] a,
                         input logic [7:0] d, input logic [2:0] f,
                         input logic [2:0] h, input string tag);
        logic [3:0] e;
        logic       hit;
        logic       flush;
        exp_t       it;
        wr = w; rd = r; addr = a; wdata = d; fws = f; hws = h;
        hit  = w && (a == ADDR);
        e[0] = hit && d[0] && sup[0];
        e[1] = hit && d[1] && sup[0] && !(busy0 && m_nak[1] != 0);
        e[2] = hit && d[4] && sup[1];
        e[3] = hit && d[5] && sup[1] && !(busy1 && m_nak[2] != 0);
        #1;
        if (r && a == ADDR) begin
            checks++;
            if (rdata !== 8'h00) begin
                fails++;
                $display("FAIL R1 read data: actual %h expected 00", rdata);
            end
        end
        for (int n = 0; n < 3; n++) begin
            flush = (n == 0) ? e[0] : (n == 1) ? e[1] : e[3];
            if (f[n]) m_nak[n] = 1;
            else if (flush && (n != 0 || m_nak[n] == 2)) m_nak[n] = 0;
            else if (h[n] && m_nak[n] == 0) m_nak[n] = 2;
        end
        it.clr = e; it.nak = nak_bits(); it.due = cycle + 1; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        wr = 1'b0; rd = 1'b0; fws = '0; hws = '0;
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 1'b0, 8'h00, 8'h00, 3'b000, 3'b000, tag);
    endtask

    // monitor: compares the queue head one edge after its stimulus
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cycle) begin
            exp_t it;
            logic [3:0] got_c;
            logic [2:0] got_n;
            it = q.pop_front();
            got_c = {c_sie, c_cpu, c_wr, c_rd};
            got_n = {n_in, n_wr, n_rd};
            checks++;
            if (got_c !== it.clr || got_n !== it.nak) begin
                fails++;
                $display("FAIL %s: actual clr=%b nak=%b expected clr=%b nak=%b",
                         it.tag, got_c, got_n, it.clr, it.nak);
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++; // R11 reset state
        if ({c_sie, c_cpu, c_wr, c_rd, n_in, n_wr, n_rd} !== 7'b0) begin
            fails++;
            $display("FAIL R11 reset: actual %b expected 0000000",
                     {c_sie, c_cpu, c_wr, c_rd, n_in, n_wr, n_rd});
        end
        rst_n = 1'b1;
        @(negedge clk);
        idle("R11 after reset");

        // R2 single bits
        drive(1, 0, ADDR, 8'h01, 0, 0, "R2 bit0");
        idle("R2 pulse ends");
        drive(1, 0, ADDR, 8'h02, 0, 0, "R2 bit1");
        drive(1, 0, ADDR, 8'h10, 0, 0, "R2 bit4");
        drive(1, 0, ADDR, 8'h20, 0, 0, "R2 bit5");
        idle("R2 pulse ends");

        // R1 read after write
        drive(1, 0, ADDR, 8'hFF, 0, 0, "R10 all bits");
        drive(0, 1, ADDR, 8'h00, 0, 0, "R1 read");

        // R3 no-effect writes
        drive(1, 0, ADDR, 8'h00, 0, 0, "R3 zero write");
        drive(1, 0, ADDR, 8'hCC, 0, 0, "R3 unused bits");
        drive(1, 0, 8'h78, 8'h33, 0, 0, "R3 other address");
        drive(0, 1, ADDR, 8'h33, 0, 0, "R3 read only");

        // R10 several bits in one cycle
        drive(1, 0, ADDR, 8'h33, 0, 0, "R10 multi");
        idle("R10 after");

        // R4 / R6 endpoint-1 interlock
        drive(0, 0, 8'h00, 8'h00, 3'b000, 3'b100, "R9 hw set ep1");
        busy1 = 1'b1;
        drive(1, 0, ADDR, 8'h20, 0, 0, "R4 blocked");
        drive(1, 0, ADDR, 8'h10, 0, 0, "R4 cpu half still clears");
        busy1 = 1'b0;
        drive(1, 0, ADDR, 8'h20, 0, 0, "R6 ep1 flush clears nak");
        idle("R6 after");

        // R5 / R6 endpoint-0 write interlock
        drive(0, 0, 8'h00, 8'h00, 3'b010, 3'b000, "R9 fw set ep0 wr");
        busy0 = 1'b1;
        drive(1, 0, ADDR, 8'h02, 0, 0, "R5 blocked");
        busy1 = 1'b1;
        drive(1, 0, ADDR, 8'h20, 0, 0, "R4 flag low not blocked");
        busy1 = 1'b0;
        busy0 = 1'b0;
        drive(1, 0, ADDR, 8'h02, 0, 0, "R6 ep0 wr flush clears fw nak");

        // R7 read-side source rule
        drive(0, 0, 8'h00, 8'h00, 3'b000, 3'b001, "R9 hw set ep0 rd");
        drive(1, 0, ADDR, 8'h01, 0, 0, "R7 hw-set rd flag cleared");
        drive(0, 0, 8'h00, 8'h00, 3'b001, 3'b000, "R9 fw set ep0 rd");
        drive(1, 0, ADDR, 8'h01, 0, 0, "R7 fw-set rd flag kept");
        drive(0, 0, 8'h00, 8'h00, 3'b000, 3'b001, "R9 hw set on fw flag");
        drive(1, 0, ADDR, 8'h01, 0, 0, "R7 still fw-set");

        // R8 unsupported endpoints
        drive(0, 0, 8'h00, 8'h00, 3'b000, 3'b110, "R9 hw set both");
        sup = 2'b10;
        drive(1, 0, ADDR, 8'h33, 0, 0, "R8 ep0 unsupported");
        sup = 2'b01;
        drive(1, 0, ADDR, 8'h33, 0, 0, "R8 ep1 unsupported");
        sup = 2'b11;

        // R12 flush beats engine set; R9 firmware set beats flush
        drive(1, 0, ADDR, 8'h22, 3'b000, 3'b110, "R12 flush over hw set");
        drive(1, 0, ADDR, 8'h20, 3'b100, 3'b000, "R9 fw set over flush");
        idle("R9 after");

        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule